// File: doc/BRIEF.md
# Guarded Bidirectional Pin Bank Controller

This block sits between a processor core and a bank of general-purpose pins, by default twenty. The core supplies the value each pin drives and receives a synchronized copy of each pad's level. By default every pin is a plain output: its buffer is always on and the core sees a constant zero for that pin. A protected control register holds one per-pin bit that turns a pin bidirectional. For a pin with that bit set, a separate unprotected 32-bit output-enable register chooses whether the pin drives its pad or releases it and listens.

The protected register can only be changed after a two-word key sequence has been written to a pair of key registers. There are several lock regions, two by default, each with its own pair of keys and its own lock state. Only one region, chosen by a parameter, guards the control register. Reading a key register returns that region's lock state. Register access uses a single-cycle write strobe and a registered read port that always reads the presented address.

A typical setup unlocks the guarding region, writes 0x7F to the control register so that pins 0 to 6 become bidirectional, and then writes 0x08 to the output-enable register. Pin 3 then listens, pins 0 to 2 and 4 to 6 drive, and pins 7 to 19 remain output-only.

Top module: `gpio_bidir_ctrl`

## Requirements
- R1: After a synchronous reset, every lock region is locked, the control register and the output-enable register read 0, every pad output-enable is 1 (driving), core_din is 0 and pad_out is 0.
- R2: For any pin whose bidirectional bit is 0, pad_oe for that pin is 1 and core_din for that pin is 0, whatever the output-enable bit and pad_in are.
- R3: For any pin whose bidirectional bit is 1, pad_oe equals the inverse of output-enable bit i (0 drives, 1 releases the pad), and core_din follows pad_in through a two-flop synchronizer: a pad change set up before clock edge k shows on core_din after edge k+1 and not after edge k.
- R4: Output-enable bits 20 to 31 are stored and read back unchanged, and they have no effect on pad_oe or core_din.
- R5: Region r has its first key at word address 2r and its second key at 2r+1. Writing 0x68EF3490 to the first key and then 0xD172BC5A to the second opens the region, and reading either key address then returns 1 in bit 0 (0 while locked).
- R6: The control register sits at word address 2*NREGION (4 by default) in bits [19:0]. A write to it while its guarding region (region 0 by default) is not open is dropped, and a read returns the stored value.
- R7: A wrong value written to either key, or a write to the second key that does not directly follow a correct first key, locks the region, including a region that was already open.
- R8: Lock regions are independent: opening region 1 neither opens region 0 nor enables control register writes, and region 0 key writes do not change region 1's state.
- R9: A write to the output-enable register (word address 2*NREGION+1, 5 by default) changes pad_oe at the same clock edge that stores it, and pad_out takes the value of core_dout one clock edge later.
- R10: bus_rdata shows the data for the address presented before a clock edge after that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_dout | input | NPIN (20) | Output values from the core |
| core_din | output | NPIN (20) | Synchronized pad levels to the core |
| pad_in | input | NPIN (20) | Pad input levels |
| pad_out | output | NPIN (20) | Registered pad output values |
| pad_oe | output | NPIN (20) | Pad output-enable, 1 = drive |

## Verification
A corrupted lock state shows in two ways: the key address reads back a wrong status one cycle after the read, and a control write that should land is dropped or one that should be dropped lands, which the control readback and pad_oe expose at the next edge. A wrong bidirectional or output-enable bit appears on pad_oe at once. It also appears on core_din as a forced zero or a leaked pad level within two cycles of a pad change. A synchronizer of the wrong depth shows when core_din is sampled one edge and then two edges after pad_in toggles.

// File: rtl/gpio_bidir_pkg.sv
package gpio_bidir_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_t;

  localparam logic [31:0] KEY_FIRST  = 32'h68EF3490;
  localparam logic [31:0] KEY_SECOND = 32'hD172BC5A;
endpackage

// File: rtl/gpio_key_lock.sv
module gpio_key_lock
  import gpio_bidir_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_first,
  input  logic              wr_second,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_o
);
  lock_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LK_SHUT;
    end else if (wr_first) begin
      st_q <= (wdata == DATA_W'(KEY_FIRST)) ? LK_HALF : LK_SHUT;
    end else if (wr_second) begin
      st_q <= (st_q == LK_HALF && wdata == DATA_W'(KEY_SECOND)) ? LK_OPEN : LK_SHUT;
    end
  end

  assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bidir,
  input  logic oe_bit,
  input  logic pad_in,
  output logic core_din,
  output logic pad_oe
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
    end
  end

  assign core_din = bidir & sync_q[SYNC_STAGES-1];
  assign pad_oe   = ~bidir | ~oe_bit;
endmodule

// File: rtl/gpio_bidir_ctrl.sv
module gpio_bidir_ctrl
  import gpio_bidir_pkg::*;
#(
  parameter int NPIN        = 20,
  parameter int OE_W        = 32,
  parameter int DATA_W      = 32,
  parameter int NREGION     = 2,
  parameter int CTRL_REGION = 0,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * NREGION + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   core_dout,
  output logic [NPIN-1:0]   core_din,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NREGION);
  localparam logic [ADDR_W-1:0] OE_ADDR   = ADDR_W'(2 * NREGION + 1);

  logic [NREGION-1:0] region_open;
  logic [NPIN-1:0]    bidir_q;
  logic [OE_W-1:0]    oe_q;
  logic [DATA_W-1:0]  rd_nxt;

  // One key pair and lock state per region
  for (genvar r = 0; r < NREGION; r++) begin : g_region
    localparam logic [ADDR_W-1:0] KA = ADDR_W'(2 * r);
    localparam logic [ADDR_W-1:0] KB = ADDR_W'(2 * r + 1);
    gpio_key_lock #(.DATA_W(DATA_W)) lock_i (
      .clk      (clk),
      .rst      (rst),
      .wr_first (bus_wr && bus_addr == KA),
      .wr_second(bus_wr && bus_addr == KB),
      .wdata    (bus_wdata),
      .open_o   (region_open[r])
    );
  end

  // Protected bidirectional control and unprotected output-enable
  always_ff @(posedge clk) begin
    if (rst) begin
      bidir_q <= '0;
      oe_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == CTRL_ADDR && region_open[CTRL_REGION]) begin
        bidir_q <= bus_wdata[NPIN-1:0];
      end
      if (bus_addr == OE_ADDR) begin
        oe_q <= bus_wdata[OE_W-1:0];
      end
    end
  end

  // Registered pad output data
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
    end else begin
      pad_out <= core_dout;
    end
  end

  // Per-pin synchronizer and buffer control
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) cell_i (
      .clk     (clk),
      .rst     (rst),
      .bidir   (bidir_q[i]),
      .oe_bit  (oe_q[i]),
      .pad_in  (pad_in[i]),
      .core_din(core_din[i]),
      .pad_oe  (pad_oe[i])
    );
  end

  // Read path
  always_comb begin
    rd_nxt = '0;
    for (int r = 0; r < NREGION; r++) begin
      if (bus_addr == ADDR_W'(2 * r) || bus_addr == ADDR_W'(2 * r + 1)) begin
        rd_nxt = DATA_W'(region_open[r]);
      end
    end
    if (bus_addr == CTRL_ADDR) rd_nxt = DATA_W'(bidir_q);
    if (bus_addr == OE_ADDR)   rd_nxt = DATA_W'(oe_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/gpio_bidir_chk.sv
module gpio_bidir_chk
  import gpio_bidir_pkg::*;
#(
  parameter int NPIN        = 20,
  parameter int DATA_W      = 32,
  parameter int NREGION     = 2,
  parameter int CTRL_REGION = 0,
  parameter int ADDR_W      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NPIN-1:0]    core_dout,
  input logic [NPIN-1:0]    core_din,
  input logic [NPIN-1:0]    pad_out,
  input logic [NPIN-1:0]    pad_oe,
  input logic [NPIN-1:0]    bidir_q,
  input logic [NREGION-1:0] region_open
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (region_open == '0 && bidir_q == '0)); // R1

  AST_OUTONLY_DRIVES: assert property (@(posedge clk) disable iff (rst)
    ((~bidir_q & ~pad_oe) == '0)); // R2

  AST_OUTONLY_DIN_LOW: assert property (@(posedge clk) disable iff (rst)
    ((core_din & ~bidir_q) == '0)); // R2

  for (genvar r = 0; r < NREGION; r++) begin : g_reg_chk
    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
      $rose(region_open[r]) |->
        $past(bus_wr && bus_addr == ADDR_W'(2 * r + 1) && bus_wdata == DATA_W'(KEY_SECOND))); // R5
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !region_open[CTRL_REGION] |=> $stable(bidir_q)); // R6

  AST_PAD_OUT_DELAY: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pad_out == $past(core_dout))); // R9
endmodule

bind gpio_bidir_ctrl gpio_bidir_chk #(
  .NPIN(NPIN), .DATA_W(DATA_W), .NREGION(NREGION),
  .CTRL_REGION(CTRL_REGION), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .core_dout(core_dout), .core_din(core_din),
  .pad_out(pad_out), .pad_oe(pad_oe), .bidir_q(bidir_q),
  .region_open(region_open)
);

// File: tb/gpio_bidir_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bidir_ctrl_tb_top;
  localparam int NPIN = 20;
  localparam int AW   = 3;
  localparam logic [31:0] K1 = 32'h68EF3490;
  localparam logic [31:0] K2 = 32'hD172BC5A;
  localparam logic [31:0] ALL = 32'h000FFFFF;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NPIN-1:0] core_dout, core_din, pad_in, pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_bidir_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_dout(core_dout),
    .core_din(core_din), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    check("R1 pad_oe", 32'(pad_oe), ALL);
    check("R1 core_din", 32'(core_din), 0);
    check("R1 pad_out", 32'(pad_out), 0);
    rd(4, rv); check("R1 ctrl", rv, 0);
    rd(5, rv); check("R1 oe", rv, 0);
    rd(0, rv); check("R1 region0", rv, 0);
    rd(3, rv); check("R1 region1", rv, 0);
  endtask

  task automatic t_locked_drop;
    wr(4, 32'h7F);
    rd(4, rv); check("R6 ctrl dropped", rv, 0);
    check("R6 pad_oe", 32'(pad_oe), ALL);
  endtask

  task automatic t_output_only;
    wr(5, 32'h000FFFFF);
    check("R2 pad_oe with oe set", 32'(pad_oe), ALL);
    pad_in = '1;
    repeat (3) @(negedge clk);
    check("R2 core_din low", 32'(core_din), 0);
    wr(5, 32'h0);
  endtask

  task automatic t_bad_keys;
    wr(0, 32'h12345678); wr(1, K2);
    rd(0, rv); check("R7 wrong first", rv, 0);
    wr(1, K2);
    rd(1, rv); check("R7 second alone", rv, 0);
    wr(0, K1); wr(1, 32'hDEADBEEF);
    rd(0, rv); check("R7 wrong second", rv, 0);
    wr(4, 32'h7F);
    rd(4, rv); check("R7 ctrl dropped", rv, 0);
  endtask

  task automatic t_other_region;
    wr(2, K1); wr(3, K2);
    rd(2, rv); check("R8 region1 open", rv, 1);
    rd(0, rv); check("R8 region0 still shut", rv, 0);
    wr(4, 32'h7F);
    rd(4, rv); check("R8 ctrl dropped", rv, 0);
  endtask

  task automatic t_unlock;
    wr(0, K1); wr(1, K2);
    rd(1, rv); check("R5 region0 open", rv, 1);
    rd(3, rv); check("R8 region1 unchanged", rv, 1);
    wr(4, 32'h7F);
    rd(4, rv); check("R5 ctrl written", rv, 32'h7F);
  endtask

  task automatic t_bidir;
    // pin3 bidir/listen, pin0 bidir/drive, pin10 out-only with oe=1, pin12 out-only oe=0
    wr(5, 32'h00000408);
    check("R9 R3 pad_oe at write edge", 32'(pad_oe), 32'h000FFFF7);
    check("R3 core_din follows pad", 32'(core_din), 32'h7F);
    @(negedge clk); pad_in = '0;
    @(negedge clk);
    check("R3 one edge still old", 32'(core_din), 32'h7F);
    @(negedge clk);
    check("R3 two edges new", 32'(core_din), 0);
    pad_in = 20'h00408;
    repeat (2) @(negedge clk);
    check("R2 R3 pin3 only", 32'(core_din), 32'h8);
  endtask

  task automatic t_high_oe;
    wr(5, 32'hFFF00008);
    rd(5, rv); check("R4 readback", rv, 32'hFFF00008);
    check("R4 pad_oe", 32'(pad_oe), 32'h000FFFF7);
    check("R4 core_din", 32'(core_din), 32'h8);
  endtask

  task automatic t_dout;
    @(negedge clk); core_dout = 20'hA5A5A;
    @(negedge clk);
    check("R9 pad_out", 32'(pad_out), 32'h000A5A5A);
    core_dout = 20'h5A5A5;
    @(negedge clk);
    check("R9 pad_out second", 32'(pad_out), 32'h0005A5A5);
  endtask

  task automatic t_read_map;
    rd(6, rv); check("R10 unmapped 6", rv, 0);
    rd(7, rv); check("R10 unmapped 7", rv, 0);
    rd(4, rv); check("R10 ctrl read", rv, 32'h7F);
  endtask

  task automatic t_relock;
    wr(0, 32'h0);
    rd(0, rv); check("R7 relocked", rv, 0);
    wr(4, 32'h0);
    rd(4, rv); check("R7 ctrl kept", rv, 32'h7F);
  endtask

  initial begin
    fork
      begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        core_dout = '0; pad_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_locked_drop();
        t_output_only();
        t_bad_keys();
        t_other_region();
        t_unlock();
        t_bidir();
        t_high_oe();
        t_dout();
        t_read_map();
        t_relock();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule